// File: doc/BRIEF.md
# Hardware Information Register Read Gate

This block answers requests to read a small set of hardware information values that user-mode code may be allowed to see: the CPU number, the cache-sync step size, the cycle counter and its resolution, the first performance counter, and a single feature flag from a configuration word. A request carries a register number and a flag saying whether the core is currently privileged. The block returns either the selected value or a reserved-instruction fault.

Access is controlled by a software-written enable mask with one bit per register number. Privileged requests ignore the mask. Register numbers that have no source behind them always fault. The mask is loaded through a simple write port, and every request is answered exactly one clock later with a one-cycle valid pulse.

Top module: `hwreg_read_gate`

## Requirements
- R1: After reset the enable mask is all zeros, so an unprivileged read of any register faults.
- R2: A mask write (maskWrEn high) updates the mask at the clock edge. A request presented in the same cycle as the write is judged against the old mask. Requests from the next cycle on use the new mask.
- R3: A read of register n (0 to 5) succeeds when privMode is high or bit n of the mask is set. Otherwise rspFault is 1 and rspData is zero.
- R4: Register 0 returns bits 9:0 of baseReg, zero-extended.
- R5: Register 1 returns syncStep unchanged.
- R6: Register 2 returns the 32-bit cycleCount sign-extended to DATA_W bits.
- R7: Register 3 returns cycleRes unchanged.
- R8: Register 4 returns perfCount0 unchanged.
- R9: Register 5 returns bit FEAT_BIT (default 13) of featCfgWord, zero-extended.
- R10: Register numbers 6 to 31 fault with zero data even when privMode is high, whatever the mask holds.
- R11: Each request with reqValid high gives rspValid high for exactly one cycle, in the cycle after the request. Back-to-back requests give back-to-back responses. rspValid is low when no request was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| maskWrEn | input | 1 | Load the enable mask |
| maskWrData | input | 32 | New enable mask value |
| reqValid | input | 1 | Read request strobe |
| reqRegNum | input | 5 | Register number to read |
| privMode | input | 1 | Core is in privileged mode; bypasses the mask |
| baseReg | input | DATA_W | Exception base value; low bits hold the CPU number |
| syncStep | input | DATA_W | Cache-sync step size |
| cycleCount | input | 32 | Cycle counter |
| cycleRes | input | DATA_W | Cycle counter resolution |
| perfCount0 | input | DATA_W | Performance counter 0 |
| featCfgWord | input | 32 | Configuration word holding the feature flag |
| rspValid | output | 1 | Response valid, one cycle per request |
| rspFault | output | 1 | Reserved-instruction fault for this response |
| rspData | output | DATA_W | Read data; zero on a fault |

## Verification
The bench builds the block with its defaults: DATA_W of 64, a 5-bit register number (a 32-bit mask) and FEAT_BIT of 13. The 64-bit data width makes the sign extension of the cycle counter visible in the upper word. It also shows that the CPU-number field and the feature flag clear the upper bits. The full 5-bit register space lets the bench reach the unbacked numbers up to 31, including a mask bit set above register 5.

// File: rtl/hwrg_pkg.sv
package hwrg_pkg;
  localparam int NUM_SRC = 6;
  localparam int SEL_W   = $clog2(NUM_SRC);

  typedef struct packed {
    logic             capture;
    logic             fault;
    logic [SEL_W-1:0] sel;
  } ctrlStrobes_t;
endpackage

// File: rtl/hwrg_ctrl.sv
module hwrg_ctrl
  import hwrg_pkg::*;
#(
  parameter int REG_NUM_W = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        maskWrEn,
  input  logic [(1<<REG_NUM_W)-1:0]   maskWrData,
  input  logic                        reqValid,
  input  logic [REG_NUM_W-1:0]        reqRegNum,
  input  logic                        privMode,
  output ctrlStrobes_t                strobes
);
  localparam int MASK_W = 1 << REG_NUM_W;

  logic [MASK_W-1:0] enableMask;
  logic              inRange;
  logic              permitted;

  always_ff @(posedge clk) begin
    if (!rst_n)        enableMask <= '0;
    else if (maskWrEn) enableMask <= maskWrData;
  end

  always_comb begin
    inRange   = (int'(reqRegNum) < NUM_SRC);
    permitted = privMode || enableMask[reqRegNum];
    strobes.capture = reqValid;
    strobes.fault   = !(inRange && permitted);
    strobes.sel     = reqRegNum[SEL_W-1:0];
  end
endmodule

// File: rtl/hwrg_datapath.sv
module hwrg_datapath
  import hwrg_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int CPUNUM_W = 10,
  parameter int FEAT_BIT = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] baseReg,
  input  logic [DATA_W-1:0] syncStep,
  input  logic [31:0]       cycleCount,
  input  logic [DATA_W-1:0] cycleRes,
  input  logic [DATA_W-1:0] perfCount0,
  input  logic [31:0]       featCfgWord,
  output logic              rspValid,
  output logic              rspFault,
  output logic [DATA_W-1:0] rspData
);
  logic [DATA_W-1:0] srcVal;

  always_comb begin
    case (strobes.sel)
      SEL_W'(0): srcVal = DATA_W'(baseReg[CPUNUM_W-1:0]);
      SEL_W'(1): srcVal = syncStep;
      SEL_W'(2): srcVal = DATA_W'($signed(cycleCount));
      SEL_W'(3): srcVal = cycleRes;
      SEL_W'(4): srcVal = perfCount0;
      SEL_W'(5): srcVal = DATA_W'(featCfgWord[FEAT_BIT]);
      default:   srcVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rspValid <= 1'b0;
      rspFault <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strobes.capture;
      if (strobes.capture) begin
        rspFault <= strobes.fault;
        rspData  <= strobes.fault ? '0 : srcVal;
      end
    end
  end
endmodule

// File: rtl/hwreg_read_gate.sv
module hwreg_read_gate
  import hwrg_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int REG_NUM_W = 5,
  parameter int CPUNUM_W  = 10,
  parameter int FEAT_BIT  = 13
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      maskWrEn,
  input  logic [(1<<REG_NUM_W)-1:0] maskWrData,
  input  logic                      reqValid,
  input  logic [REG_NUM_W-1:0]      reqRegNum,
  input  logic                      privMode,
  input  logic [DATA_W-1:0]         baseReg,
  input  logic [DATA_W-1:0]         syncStep,
  input  logic [31:0]               cycleCount,
  input  logic [DATA_W-1:0]         cycleRes,
  input  logic [DATA_W-1:0]         perfCount0,
  input  logic [31:0]               featCfgWord,
  output logic                      rspValid,
  output logic                      rspFault,
  output logic [DATA_W-1:0]         rspData
);
  ctrlStrobes_t strobes;

  hwrg_ctrl #(.REG_NUM_W(REG_NUM_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .maskWrEn(maskWrEn), .maskWrData(maskWrData),
    .reqValid(reqValid), .reqRegNum(reqRegNum), .privMode(privMode),
    .strobes(strobes)
  );

  hwrg_datapath #(.DATA_W(DATA_W), .CPUNUM_W(CPUNUM_W), .FEAT_BIT(FEAT_BIT)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes),
    .baseReg(baseReg), .syncStep(syncStep), .cycleCount(cycleCount),
    .cycleRes(cycleRes), .perfCount0(perfCount0), .featCfgWord(featCfgWord),
    .rspValid(rspValid), .rspFault(rspFault), .rspData(rspData)
  );
endmodule

// File: rtl/hwreg_read_gate_chk.sv
module hwreg_read_gate_chk #(
  parameter int DATA_W    = 64,
  parameter int REG_NUM_W = 5,
  parameter int CPUNUM_W  = 10
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reqValid,
  input logic [REG_NUM_W-1:0] reqRegNum,
  input logic                 privMode,
  input logic [DATA_W-1:0]    baseReg,
  input logic [31:0]          cycleCount,
  input logic                 rspValid,
  input logic                 rspFault,
  input logic [DATA_W-1:0]    rspData
);
  logic [DATA_W-1:0] cycWide;
  assign cycWide = DATA_W'($signed(cycleCount));

  a_r11_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> rspValid);
  a_r11_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> !rspValid);
  a_r3_fault_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && rspFault) |-> (rspData == '0));
  a_r10_high_num_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && int'(reqRegNum) > 5) |=> rspFault);
  a_r6_cycle_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && privMode && reqRegNum == REG_NUM_W'(2)) |=> (rspData == $past(cycWide)));
  a_r4_cpunum_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && privMode && reqRegNum == '0) |=>
      (rspData[CPUNUM_W-1:0] == $past(baseReg[CPUNUM_W-1:0]) &&
       rspData[DATA_W-1:CPUNUM_W] == '0));
endmodule

bind hwreg_read_gate hwreg_read_gate_chk #(
  .DATA_W(DATA_W), .REG_NUM_W(REG_NUM_W), .CPUNUM_W(CPUNUM_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqRegNum(reqRegNum),
  .privMode(privMode), .baseReg(baseReg), .cycleCount(cycleCount),
  .rspValid(rspValid), .rspFault(rspFault), .rspData(rspData)
);

// File: tb/test_hwreg_read_gate.sv
module test_hwreg_read_gate;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          maskWrEn = 1'b0;
  logic [31:0]   maskWrData = '0;
  logic          reqValid = 1'b0;
  logic [4:0]    reqRegNum = '0;
  logic          privMode = 1'b0;
  logic [DW-1:0] baseReg = 64'hDEAD_BEEF_1234_5ABC;
  logic [DW-1:0] syncStep = 64'h0000_0000_0000_0040;
  logic [31:0]   cycleCount = 32'h8000_0001;
  logic [DW-1:0] cycleRes = 64'h0000_0000_0000_0002;
  logic [DW-1:0] perfCount0 = 64'h0123_4567_89AB_CDEF;
  logic [31:0]   featCfgWord = 32'h0000_2000;
  logic          rspValid, rspFault;
  logic [DW-1:0] rspData;

  int tests = 0;
  int fails = 0;
  logic [31:0] tbMask = '0;

  typedef struct {
    logic          fault;
    logic [DW-1:0] data;
    string         tag;
  } expItem_t;
  expItem_t sbQueue[$];

  always #10 clk = ~clk;

  hwreg_read_gate i_hwreg_read_gate (
    .clk(clk), .rst_n(rst_n), .maskWrEn(maskWrEn), .maskWrData(maskWrData),
    .reqValid(reqValid), .reqRegNum(reqRegNum), .privMode(privMode),
    .baseReg(baseReg), .syncStep(syncStep), .cycleCount(cycleCount),
    .cycleRes(cycleRes), .perfCount0(perfCount0), .featCfgWord(featCfgWord),
    .rspValid(rspValid), .rspFault(rspFault), .rspData(rspData)
  );

  function automatic logic [DW-1:0] srcOf(input int n);
    case (n)
      0: return {54'd0, baseReg[9:0]};
      1: return syncStep;
      2: return {{32{cycleCount[31]}}, cycleCount};
      3: return cycleRes;
      4: return perfCount0;
      5: return {63'd0, featCfgWord[13]};
      default: return '0;
    endcase
  endfunction

  task automatic check(input string tag, input logic cond, input string msg);
    tests++;
    if (!cond) begin
      fails++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  // Driver: presents one request in the next cycle and queues its expected answer.
  task automatic issue(input int n, input logic priv, input string tag,
                       input logic wr = 1'b0, input logic [31:0] wrVal = '0);
    expItem_t it;
    @(negedge clk);
    reqValid  = 1'b1;
    reqRegNum = 5'(n);
    privMode  = priv;
    maskWrEn  = wr;
    maskWrData = wrVal;
    it.fault = !((n < 6) && (priv || tbMask[n]));
    it.data  = it.fault ? '0 : srcOf(n);
    it.tag   = tag;
    sbQueue.push_back(it);
    if (wr) tbMask = wrVal;
  endtask

  task automatic idle();
    @(negedge clk);
    reqValid = 1'b0;
    maskWrEn = 1'b0;
  endtask

  task automatic writeMask(input logic [31:0] v);
    @(negedge clk);
    reqValid = 1'b0;
    maskWrEn = 1'b1;
    maskWrData = v;
    tbMask = v;
    @(negedge clk);
    maskWrEn = 1'b0;
  endtask

  // Monitor: compares each response with the head of the scoreboard.
  always @(negedge clk) begin
    if (rst_n && rspValid) begin
      if (sbQueue.size() == 0) begin
        check("R11", 1'b0, "rspValid with no request outstanding");
      end else begin
        expItem_t e;
        e = sbQueue.pop_front();
        check(e.tag, rspFault == e.fault && rspData == e.data,
              $sformatf("fault=%0b data=%h expected fault=%0b data=%h",
                        rspFault, rspData, e.fault, e.data));
      end
    end
  end

  bit done = 0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", rspValid == 1'b0, $sformatf("reset rspValid=%0b expected 0", rspValid));
    // R1: mask is zero after reset
    issue(2, 1'b0, "R1");
    issue(0, 1'b0, "R1");
    idle();
    // R4..R9 through privileged bypass, R6 with negative counter
    issue(0, 1'b1, "R4");
    issue(1, 1'b1, "R5");
    issue(2, 1'b1, "R6");
    issue(3, 1'b1, "R7");
    issue(4, 1'b1, "R8");
    issue(5, 1'b1, "R9");
    idle();
    cycleCount  = 32'h7FFF_FFF0;
    featCfgWord = 32'hFFFF_DFFF;
    issue(2, 1'b1, "R6");
    issue(5, 1'b1, "R9");
    idle();
    // R10: unbacked numbers fault even privileged, even with mask bits set
    writeMask(32'hFFFF_FFFF);
    issue(6, 1'b1, "R10");
    issue(31, 1'b0, "R10");
    idle();
    // R3: per-bit enable for unprivileged reads
    writeMask(32'h0000_0014);
    issue(2, 1'b0, "R3");
    issue(4, 1'b0, "R3");
    issue(3, 1'b0, "R3");
    issue(0, 1'b0, "R3");
    idle();
    // R2: write and request in the same cycle use the old mask
    issue(1, 1'b0, "R2", 1'b1, 32'h0000_0002);
    issue(1, 1'b0, "R2");
    issue(2, 1'b0, "R2");
    idle();
    repeat (3) @(negedge clk);
    check("R11", sbQueue.size() == 0,
          $sformatf("outstanding=%0d expected 0", sbQueue.size()));
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule